// File: doc/BRIEF.md
# Queue Doorbell Write Decoder

This block sits behind the register-write port of a queue-based storage controller and handles every write that lands in the doorbell window, which starts at byte offset 0x1000. Each queue pair owns two doorbell slots. The first slot is the submission-queue tail and the second is the completion-queue head. The slots are spaced by a run-time stride, so software can spread the doorbells over wider address steps. A well-formed write loads the addressed pointer on the following clock and raises a one-cycle update strobe for that queue, so the fetch and completion engines can react.

A write can be malformed in three ways: its address is off the slot grid, it targets a queue that does not exist, or its value is not below the queue's size. Such a write changes no pointer. The block instead emits a one-cycle error event for the event dispatcher. The event carries an event type, an info code that names the fault, and the identifier of the error information log page. Writes below the doorbell window are not this block's concern and are dropped without an event.

Top module: `dbWriteDecoder`

## Requirements
- R1: For stride s, a write to 0x1000 + q*(8<<s) with an existing submission queue q and a value below its size sets that queue's tail to the value on the next clock, and `sqUpd[q]` is high for exactly that one cycle.
- R2: For stride s, a write to 0x1000 + (4<<s) + q*(8<<s) with an existing completion queue q and a value below its size sets that queue's head to the value on the next clock, and `cqUpd[q]` is high for exactly that one cycle.
- R3: A write at or above 0x1000 whose address is not a multiple of (4<<s) changes no pointer and raises an event with info code 1 (invalid doorbell).
- R4: A submission-slot write to a queue whose `sqValid` bit is low, or whose index is NQ or more, changes no pointer and raises an event with info code 0 (invalid submission queue).
- R5: A completion-slot write to a queue whose `cqValid` bit is low, or whose index is NQ or more, changes no pointer and raises an event with info code 1.
- R6: A value greater than or equal to the target queue's size changes no pointer and raises an event with info code 1. The value size-1 is accepted.
- R7: Every event has `evtType` 0 and `evtLogPage` 0x01 (the error information log page), and `evtValid` is high for one cycle, on the clock after the write.
- R8: A write below 0x1000, or any cycle with `wrEn` low, changes no pointer and raises no strobe and no event.
- R9: While `rstN` is low, all pointers are 0 and no strobe or event is raised.
- R10: A write yields at most one outcome: a single update strobe or a single event, never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write valid |
| wrAddr | input | ADDR_W | Byte address of the write |
| wrData | input | PTR_W | Written pointer value |
| stride | input | STRIDE_W | Doorbell stride exponent s |
| sqValid | input | NQ | Submission queue q exists |
| cqValid | input | NQ | Completion queue q exists |
| sqSize | input | NQ*PTR_W | Submission queue sizes, queue q in bits [q*PTR_W +: PTR_W] |
| cqSize | input | NQ*PTR_W | Completion queue sizes, same packing |
| sqTail | output | NQ*PTR_W | Submission tail pointers, same packing |
| cqHead | output | NQ*PTR_W | Completion head pointers, same packing |
| sqUpd | output | NQ | One-cycle tail update strobe per queue |
| cqUpd | output | NQ | One-cycle head update strobe per queue |
| evtValid | output | 1 | One-cycle error event |
| evtType | output | 3 | Event type, 0 for errors |
| evtInfo | output | 8 | Fault code: 0 invalid submission queue, 1 invalid doorbell |
| evtLogPage | output | 8 | Referenced log page, 0x01 |

## Verification
The bench runs the same slot mapping at stride 0 and at stride 2. This exposes a decoder that hard-codes the 4-byte spacing, or one that tests the submission/completion select bit at the wrong position, because either fault would land a write on the wrong pointer. It writes values at size-1 and at size exactly, to catch a comparison that is off by one. It probes an index just past the last queue, which a decoder without a range check would alias onto queue 0. It also probes disabled queues on both slot kinds, because swapping the two info codes is easy to do. After each write it compares every pointer against a model, so a stray load into an unaddressed queue shows up. It also checks that strobes and events fall back to zero one cycle later.

// File: rtl/dbPkg.sv
package dbPkg;
  localparam int DB_QID_W = 8;
  localparam logic [7:0] INFO_BAD_SQ = 8'd0;
  localparam logic [7:0] INFO_BAD_DB = 8'd1;
  localparam logic [2:0] EVT_ERROR   = 3'd0;
  localparam logic [7:0] PAGE_ERRLOG = 8'h01;

  typedef struct packed {
    logic                load;
    logic                isCq;
    logic [DB_QID_W-1:0] qid;
    logic                err;
    logic [7:0]          code;
  } dbCtl_t;
endpackage

// File: rtl/dbDecodeCtrl.sv
module dbDecodeCtrl
  import dbPkg::*;
#(
  parameter int NQ       = 4,
  parameter int PTR_W    = 16,
  parameter int ADDR_W   = 16,
  parameter int STRIDE_W = 4,
  parameter int BASE     = 32'h1000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [PTR_W-1:0]    wrData,
  input  logic [STRIDE_W-1:0] stride,
  input  logic [NQ-1:0]       sqValid,
  input  logic [NQ-1:0]       cqValid,
  input  logic [NQ*PTR_W-1:0] sqSize,
  input  logic [NQ*PTR_W-1:0] cqSize,
  output dbCtl_t              ctl
);
  logic [PTR_W-1:0] sqSz [NQ];
  logic [PTR_W-1:0] cqSz [NQ];

  for (genvar q = 0; q < NQ; q++) begin : g_unpack
    assign sqSz[q] = sqSize[q*PTR_W +: PTR_W];
    assign cqSz[q] = cqSize[q*PTR_W +: PTR_W];
  end

  logic [31:0]      addrW, stepW, offW, qidW;
  logic             isCq, exists;
  logic [PTR_W-1:0] selSize;

  always_comb begin
    addrW   = 32'(wrAddr);
    stepW   = 32'd4 << stride;
    offW    = addrW - 32'(BASE);
    isCq    = |(offW & stepW);
    qidW    = offW >> (32'd3 + 32'(stride));
    exists  = 1'b0;
    selSize = '0;
    for (int i = 0; i < NQ; i++) begin
      if (qidW == 32'(i)) begin
        exists  = isCq ? cqValid[i] : sqValid[i];
        selSize = isCq ? cqSz[i] : sqSz[i];
      end
    end

    ctl      = '0;
    ctl.isCq = isCq;
    ctl.qid  = qidW[DB_QID_W-1:0];
    if (wrEn && addrW >= 32'(BASE)) begin
      if ((addrW & (stepW - 32'd1)) != 32'd0) begin
        ctl.err  = 1'b1;
        ctl.code = INFO_BAD_DB;
      end else if (!exists) begin
        ctl.err  = 1'b1;
        ctl.code = isCq ? INFO_BAD_DB : INFO_BAD_SQ;
      end else if (wrData >= selSize) begin
        ctl.err  = 1'b1;
        ctl.code = INFO_BAD_DB;
      end else begin
        ctl.load = 1'b1;
      end
    end
  end

  // R8: writes outside the window or with enable low take no action
  p_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn || 32'(wrAddr) < 32'(BASE)) |-> (!ctl.load && !ctl.err));

  // R3: a low address bit set is always off the grid, whatever the stride
  p_misalign_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && 32'(wrAddr) >= 32'(BASE) && wrAddr[1:0] != 2'b00)
      |-> (ctl.err && ctl.code == INFO_BAD_DB && !ctl.load));
endmodule

// File: rtl/dbPtrPath.sv
module dbPtrPath
  import dbPkg::*;
#(
  parameter int NQ    = 4,
  parameter int PTR_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  dbCtl_t              ctl,
  input  logic [PTR_W-1:0]    wrData,
  output logic [NQ*PTR_W-1:0] sqTail,
  output logic [NQ*PTR_W-1:0] cqHead,
  output logic [NQ-1:0]       sqUpd,
  output logic [NQ-1:0]       cqUpd,
  output logic                evtValid,
  output logic [2:0]          evtType,
  output logic [7:0]          evtInfo,
  output logic [7:0]          evtLogPage
);
  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic hitSq, hitCq;
    assign hitSq = ctl.load && !ctl.isCq && ctl.qid == DB_QID_W'(q);
    assign hitCq = ctl.load &&  ctl.isCq && ctl.qid == DB_QID_W'(q);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        sqTail[q*PTR_W +: PTR_W] <= '0;
        cqHead[q*PTR_W +: PTR_W] <= '0;
        sqUpd[q] <= 1'b0;
        cqUpd[q] <= 1'b0;
      end else begin
        if (hitSq) sqTail[q*PTR_W +: PTR_W] <= wrData;
        if (hitCq) cqHead[q*PTR_W +: PTR_W] <= wrData;
        sqUpd[q] <= hitSq;
        cqUpd[q] <= hitCq;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtValid   <= 1'b0;
      evtType    <= '0;
      evtInfo    <= '0;
      evtLogPage <= '0;
    end else begin
      evtValid <= ctl.err;
      if (ctl.err) begin
        evtType    <= EVT_ERROR;
        evtInfo    <= ctl.code;
        evtLogPage <= PAGE_ERRLOG;
      end
    end
  end

  // R10: one outcome per write
  p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sqUpd, cqUpd, evtValid}));

  // R7: event fields as the dispatcher expects
  p_evt_fields_r7: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> (evtType == EVT_ERROR && evtLogPage == PAGE_ERRLOG));

  // R1: a tail load is seen as a strobe on the next cycle
  p_load_strobe_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && !ctl.isCq) |=> (sqUpd != '0));
endmodule

// File: rtl/dbWriteDecoder.sv
module dbWriteDecoder
  import dbPkg::*;
#(
  parameter int NQ       = 4,
  parameter int PTR_W    = 16,
  parameter int ADDR_W   = 16,
  parameter int STRIDE_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [PTR_W-1:0]    wrData,
  input  logic [STRIDE_W-1:0] stride,
  input  logic [NQ-1:0]       sqValid,
  input  logic [NQ-1:0]       cqValid,
  input  logic [NQ*PTR_W-1:0] sqSize,
  input  logic [NQ*PTR_W-1:0] cqSize,
  output logic [NQ*PTR_W-1:0] sqTail,
  output logic [NQ*PTR_W-1:0] cqHead,
  output logic [NQ-1:0]       sqUpd,
  output logic [NQ-1:0]       cqUpd,
  output logic                evtValid,
  output logic [2:0]          evtType,
  output logic [7:0]          evtInfo,
  output logic [7:0]          evtLogPage
);
  dbCtl_t ctl;

  dbDecodeCtrl #(
    .NQ(NQ), .PTR_W(PTR_W), .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .BASE(32'h1000)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .stride(stride), .sqValid(sqValid), .cqValid(cqValid),
    .sqSize(sqSize), .cqSize(cqSize), .ctl(ctl)
  );

  dbPtrPath #(.NQ(NQ), .PTR_W(PTR_W)) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData),
    .sqTail(sqTail), .cqHead(cqHead), .sqUpd(sqUpd), .cqUpd(cqUpd),
    .evtValid(evtValid), .evtType(evtType), .evtInfo(evtInfo),
    .evtLogPage(evtLogPage)
  );
endmodule

// File: tb/sim_dbWriteDecoder.sv
module sim_dbWriteDecoder;
  localparam int NQ = 4;
  localparam int PW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [PW-1:0] wrData = '0;
  logic [3:0] stride = '0;
  logic [NQ-1:0] sqValid = 4'b0111;
  logic [NQ-1:0] cqValid = 4'b1011;
  logic [NQ*PW-1:0] sqSize = {16'd64, 16'd32, 16'd16, 16'd8};
  logic [NQ*PW-1:0] cqSize = {16'd64, 16'd32, 16'd16, 16'd8};
  logic [NQ*PW-1:0] sqTail, cqHead;
  logic [NQ-1:0] sqUpd, cqUpd;
  logic evtValid;
  logic [2:0] evtType;
  logic [7:0] evtInfo, evtLogPage;

  always #5 clk = ~clk;

  dbWriteDecoder u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .stride(stride), .sqValid(sqValid), .cqValid(cqValid), .sqSize(sqSize),
    .cqSize(cqSize), .sqTail(sqTail), .cqHead(cqHead), .sqUpd(sqUpd),
    .cqUpd(cqUpd), .evtValid(evtValid), .evtType(evtType), .evtInfo(evtInfo),
    .evtLogPage(evtLogPage)
  );

  // kind: 0 nothing, 1 tail load, 2 head load, 3 error event
  typedef struct packed {
    logic [3:0]  s;
    logic [15:0] addr;
    logic [15:0] data;
    logic [1:0]  kind;
    logic [2:0]  q;
    logic [7:0]  info;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 16'h1000, 16'd5,  2'd1, 3'd0, 8'd0}, // R1 tail q0
    '{4'd0, 16'h100C, 16'd15, 2'd2, 3'd1, 8'd0}, // R2 head q1
    '{4'd0, 16'h1002, 16'd1,  2'd3, 3'd0, 8'd1}, // R3 off grid
    '{4'd0, 16'h1018, 16'd1,  2'd3, 3'd0, 8'd0}, // R4 disabled sq3
    '{4'd0, 16'h1014, 16'd1,  2'd3, 3'd0, 8'd1}, // R5 disabled cq2
    '{4'd0, 16'h1008, 16'd16, 2'd3, 3'd0, 8'd1}, // R6 value == size
    '{4'd0, 16'h1008, 16'd15, 2'd1, 3'd1, 8'd0}, // R6 size-1 accepted
    '{4'd0, 16'h0FFC, 16'd3,  2'd0, 3'd0, 8'd0}, // R8 below window
    '{4'd0, 16'h1020, 16'd1,  2'd3, 3'd0, 8'd0}, // R4 index == NQ
    '{4'd2, 16'h1040, 16'd31, 2'd1, 3'd2, 8'd0}, // R1 stride 2 tail q2
    '{4'd2, 16'h1070, 16'd63, 2'd2, 3'd3, 8'd0}, // R2 stride 2 head q3
    '{4'd2, 16'h1008, 16'd1,  2'd3, 3'd0, 8'd1}, // R3 stride 2 off grid
    '{4'd2, 16'h1010, 16'd8,  2'd3, 3'd0, 8'd1}, // R6 stride 2 head q0 too big
    '{4'd2, 16'h1010, 16'd7,  2'd2, 3'd0, 8'd0}  // R2 stride 2 head q0
  };

  int nChk = 0;
  int nBad = 0;
  bit finished = 1'b0;
  logic [PW-1:0] mSq [NQ];
  logic [PW-1:0] mCq [NQ];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chkPtrs(input string req);
    for (int q = 0; q < NQ; q++) begin
      chk(sqTail[q*PW +: PW] == mSq[q], req, "tail", sqTail[q*PW +: PW], mSq[q]);
      chk(cqHead[q*PW +: PW] == mCq[q], req, "head", cqHead[q*PW +: PW], mCq[q]);
    end
  endtask

  task automatic chkQuiet(input string req);
    chk(sqUpd == '0 && cqUpd == '0, req, "strobes",
        {cqUpd, sqUpd}, 0);
    chk(!evtValid, req, "evtValid", evtValid, 0);
  endtask

  initial begin
    for (int q = 0; q < NQ; q++) begin
      mSq[q] = '0;
      mCq[q] = '0;
    end
    repeat (3) @(negedge clk);
    // R9: state held in reset
    chkPtrs("R9");
    chkQuiet("R9");
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [NQ-1:0] expSq, expCq;
      v = VECS[i];
      stride = v.s;
      wrAddr = v.addr;
      wrData = v.data;
      wrEn = 1'b1;
      @(negedge clk);
      wrEn = 1'b0;
      expSq = (v.kind == 2'd1) ? NQ'(1) << v.q : '0;
      expCq = (v.kind == 2'd2) ? NQ'(1) << v.q : '0;
      if (v.kind == 2'd1) mSq[v.q] = v.data;
      if (v.kind == 2'd2) mCq[v.q] = v.data;
      chk(sqUpd == expSq, "R1", $sformatf("vec %0d sqUpd", i), sqUpd, expSq);
      chk(cqUpd == expCq, "R2", $sformatf("vec %0d cqUpd", i), cqUpd, expCq);
      chk(evtValid == (v.kind == 2'd3), "R10", $sformatf("vec %0d evtValid", i),
          evtValid, v.kind == 2'd3);
      if (v.kind == 2'd3) begin
        chk(evtInfo == v.info, "R3", $sformatf("vec %0d info", i), evtInfo, v.info);
        chk(evtType == 3'd0, "R7", "evtType", evtType, 0);
        chk(evtLogPage == 8'h01, "R7", "evtLogPage", evtLogPage, 8'h01);
      end
      chkPtrs($sformatf("R6 vec %0d", i));
      @(negedge clk);
      // R7: event and strobes last one cycle
      chkQuiet("R7");
    end

    // R8: enable low at a live slot does nothing
    stride = 4'd0;
    wrAddr = 16'h1000;
    wrData = 16'd3;
    @(negedge clk);
    @(negedge clk);
    chkQuiet("R8");
    chkPtrs("R8");

    // R9: reset mid-run clears every pointer
    rstN = 1'b0;
    @(negedge clk);
    for (int q = 0; q < NQ; q++) begin
      mSq[q] = '0;
      mCq[q] = '0;
    end
    chkPtrs("R9");
    chkQuiet("R9");
    rstN = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule